// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block sits between synchronous logic and an external 16-bit asynchronous static RAM. On the user side it takes one request at a time through a valid/ready handshake: an address, a read or write flag, write data and a two-bit byte mask. On the memory side it produces chip enable, output enable, write enable and two byte-lane enables (all active low), an address bus, and a data bus split into output value, output enable and input value. The pad tristate cells are expected outside.

Every minimum memory timing is given in nanoseconds as a parameter together with the clock period. Each is converted to a cycle count by rounding up, with a minimum of one cycle, so another speed grade or clock needs only new parameter values. After reset the block holds `req_ready` low for a power-up delay of 100 us by default. Only after that does it accept any access.

A write drives address, data, chip enable and the selected lanes for one setup cycle. Write enable is then low for the write pulse. Write enable rises alone, and everything else is held for one more cycle, so a single edge ends the write. A read holds chip enable, output enable and both lanes low for the read time. It samples the data bus on the edge that ends that window, with the address still unchanged. It then spends one cycle with every strobe released before any further access can start.

Top module: `sram_timing_ctrl`

## Requirements
- R1: From reset release, `req_ready` stays low and `mem_ce_n` stays high for at least the power-up cycle count (ceil(PWRUP_NS/CLK_NS)), and any request offered during that time is ignored; `req_ready` rises within three cycles after the count ends.
- R2: A write with a nonzero mask first spends one cycle with chip enable and the selected lanes low, address and data driven and write enable high, then holds write enable low for WP cycles, where WP is the largest of the rounded-up write pulse, chip-enable-to-end, address-to-end, lane-to-end and data-setup times and of the rounded-up write cycle time minus two.
- R3: A write ends by raising write enable while chip enable, the lanes, the address and the driven data stay unchanged for one more cycle, so the whole write occupies WP+2 cycles after the accepting edge.
- R4: Mask bit 1 selects the upper lane (`mem_ub_n`, data bits 15:8) and mask bit 0 selects the lower lane (`mem_lb_n`, data bits 7:0); only the selected bytes change in memory.
- R5: A write with mask 2'b00 never pulls write enable or chip enable low, and `req_ready` returns two cycles after the accepting edge.
- R6: A read holds chip enable, output enable and both lanes low, and write enable high, for RD cycles, where RD is the largest of the rounded-up read cycle, address-to-data, chip-enable-to-data, output-enable-to-data and lane-to-data times. The data bus is sampled on the edge that ends this window, while the address is still held.
- R7: Read data appears on `rd_data` with a single-cycle `rd_valid` pulse in the cycle after the read window.
- R8: Every read is followed by a turnaround cycle with output enable and chip enable high and the data drivers off; the data drivers are never on while output enable is low, and they turn on only after at least one cycle with output enable high.
- R9: A request is accepted only on an edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low from the accepting edge until the access has finished (read: RD+2 cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and powered up; request accepted when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte mask for writes; bit 1 upper byte, bit 0 lower byte |
| rd_data | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse marking returned read data |
| mem_addr | output | AW | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_dq_out | output | 16 | Data value to drive onto the memory bus |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 16 | Data seen on the memory bus |

## Verification
All strobes are registered on the edge that accepts or advances a request. A nonzero write therefore returns `req_ready` WP+3 falling edges after the accepting edge, a masked-off write two falling edges after it, and a read puts `rd_valid` one falling edge after its RD-cycle window and `req_ready` one falling edge later. The bench drives inputs and samples everything on falling edges and counts falling edges from the accepting edge, so each check lands in the exact cycle its result is due. Its memory model counts low cycles of the write overlap and of the read enables on the same falling edges. It latches data only on the terminating edge, and returns garbage until RD falling edges of read enable have passed, so a read sampled early or late mismatches the reference image computed in the bench.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WPUL,
    ST_WHLD,
    ST_NOP,
    ST_RACT,
    ST_RTRN
  } ctrl_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;

endmodule

// File: rtl/sram_pwr_gate.sv
module sram_pwr_gate #(
  parameter int HOLD_CYC = 10000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);

  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != LAST);
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = !cnt_en;

endmodule

// File: rtl/sram_step_timer.sv
module sram_step_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_timing_ctrl.sv
module sram_timing_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 18,
  parameter int CLK_NS    = 10,
  parameter int PWRUP_NS  = 100000,
  parameter int T_WC_NS   = 10,
  parameter int T_PWE_NS  = 7,
  parameter int T_SCE_NS  = 7,
  parameter int T_AW_NS   = 7,
  parameter int T_BW_NS   = 7,
  parameter int T_SD_NS   = 6,
  parameter int T_RC_NS   = 10,
  parameter int T_AA_NS   = 10,
  parameter int T_ACE_NS  = 10,
  parameter int T_DOE_NS  = 5,
  parameter int T_DBE_NS  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_mask,
  output logic [15:0]   rd_data,
  output logic          rd_valid,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  localparam int PWR_CYC  = ns_to_cyc(PWRUP_NS, CLK_NS);
  localparam int WPUL_CYC = max_int(
      max_int(max_int(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SCE_NS, CLK_NS)),
              max_int(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_BW_NS, CLK_NS))),
      max_int(ns_to_cyc(T_SD_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS) - 2));
  localparam int RD_CYC = max_int(
      max_int(max_int(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
              max_int(ns_to_cyc(T_ACE_NS, CLK_NS), ns_to_cyc(T_DOE_NS, CLK_NS))),
      ns_to_cyc(T_DBE_NS, CLK_NS));
  localparam int TW = $clog2(max_int(WPUL_CYC, RD_CYC) + 1);
  localparam logic [TW-1:0] WPUL_VAL = TW'(WPUL_CYC);
  localparam logic [TW-1:0] RD_VAL   = TW'(RD_CYC);

  logic        srst_n;
  logic        pwr_done;
  logic        tmr_load;
  logic [TW-1:0] tmr_val;
  logic        tmr_done;
  logic        accept;

  ctrl_state_e state_q, state_d;

  logic [AW-1:0] addr_q;
  logic [15:0]   wdata_q;
  logic [1:0]    mask_q;
  logic [15:0]   rd_data_q;
  logic          rd_valid_q;
  logic          ce_n_q, oe_n_q, we_n_q, ub_n_q, lb_n_q, dq_oe_q;

  logic          ce_n_d, oe_n_d, we_n_d, ub_n_d, lb_n_d, dq_oe_d;
  logic          in_write_d;
  logic [1:0]    lane_src;
  logic          capture;

  sram_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (srst_n)
  );

  sram_pwr_gate #(.HOLD_CYC(PWR_CYC)) u_pwr_gate (
    .clk   (clk),
    .rst_n (srst_n),
    .done  (pwr_done)
  );

  sram_step_timer #(.W(TW)) u_step_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign req_ready = pwr_done && (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept) begin
        if (!req_write)           state_d = ST_RACT;
        else if (req_mask == 2'b00) state_d = ST_NOP;
        else                      state_d = ST_WSET;
      end
      ST_WSET: state_d = ST_WPUL;
      ST_WPUL: if (tmr_done) state_d = ST_WHLD;
      ST_WHLD: state_d = ST_IDLE;
      ST_NOP:  state_d = ST_IDLE;
      ST_RACT: if (tmr_done) state_d = ST_RTRN;
      ST_RTRN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = ((state_d == ST_WPUL) && (state_q != ST_WPUL)) ||
                    ((state_d == ST_RACT) && (state_q != ST_RACT));
  assign tmr_val  = (state_d == ST_RACT) ? RD_VAL : WPUL_VAL;

  // Strobe values for the coming cycle, registered so the pins never glitch.
  always_comb begin
    in_write_d = (state_d == ST_WSET) || (state_d == ST_WPUL) || (state_d == ST_WHLD);
    lane_src   = accept ? req_mask : mask_q;
    ce_n_d     = !(in_write_d || (state_d == ST_RACT));
    oe_n_d     = (state_d != ST_RACT);
    we_n_d     = (state_d != ST_WPUL);
    dq_oe_d    = in_write_d;
    ub_n_d     = 1'b1;
    lb_n_d     = 1'b1;
    if (state_d == ST_RACT) begin
      ub_n_d = 1'b0;
      lb_n_d = 1'b0;
    end else if (in_write_d) begin
      ub_n_d = !lane_src[1];
      lb_n_d = !lane_src[0];
    end
  end

  assign capture = (state_q == ST_RACT) && tmr_done;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q    <= ST_IDLE;
      ce_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      we_n_q     <= 1'b1;
      ub_n_q     <= 1'b1;
      lb_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ce_n_q     <= ce_n_d;
      oe_n_q     <= oe_n_d;
      we_n_q     <= we_n_d;
      ub_n_q     <= ub_n_d;
      lb_n_q     <= lb_n_d;
      dq_oe_q    <= dq_oe_d;
      rd_valid_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rd_data_q <= '0;
    end else if (capture) begin
      rd_data_q <= mem_dq_in;
    end
  end

  assign rd_data    = rd_data_q;
  assign rd_valid   = rd_valid_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = ce_n_q;
  assign mem_oe_n   = oe_n_q;
  assign mem_we_n   = we_n_q;
  assign mem_ub_n   = ub_n_q;
  assign mem_lb_n   = lb_n_q;
  assign mem_dq_oe  = dq_oe_q;

endmodule

module sram_timing_ctrl_chk #(
  parameter int AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rd_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic [15:0]   mem_dq_out,
  input logic          mem_dq_oe
);

  // R9
  idle_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n));

  // R2
  we_inside_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe && !(mem_ub_n && mem_lb_n)));

  // R2
  write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(mem_dq_oe) && $stable(mem_addr) && $stable(mem_dq_out)));

  // R3
  write_end_by_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable(mem_ub_n) && $stable(mem_lb_n)
                         && $stable(mem_addr) && $stable(mem_dq_out)));

  // R6
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  // R6
  read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_ub_n && !mem_lb_n));

  // R8
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> $past(mem_oe_n));

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

bind sram_timing_ctrl sram_timing_ctrl_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_ub_n   (mem_ub_n),
  .mem_lb_n   (mem_lb_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_timing_ctrl_test.sv
`timescale 1ns/1ps
module sram_timing_ctrl_test;

  localparam int AW       = 4;
  localparam int WP_EXP   = 2;   // max(ceil(7/5),ceil(7/5),ceil(7/5),ceil(7/5),ceil(6/5),ceil(10/5)-2)
  localparam int RD_EXP   = 2;   // max(ceil(10/5),ceil(10/5),ceil(10/5),ceil(5/5),ceil(5/5))
  localparam int PWR_EXP  = 400; // 2000 ns / 5 ns

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic          req_write;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_wdata;
  logic [1:0]    req_mask;
  logic [15:0]   rd_data;
  logic          rd_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [15:0]   mem_dq_out;
  logic          mem_dq_oe;
  logic [15:0]   mem_dq_in;

  int checks;
  int errors;
  int commits;
  int commits_exp;

  sram_timing_ctrl #(.AW(AW), .CLK_NS(5), .PWRUP_NS(2000)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_data(rd_data), .rd_valid(rd_valid),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- behavioural memory ----------------
  logic [15:0] model_mem [16];
  logic [15:0] ref_mem   [16];
  int          wcnt;
  int          rcnt;
  logic        rd_ok;
  logic [3:0]  wa;
  logic [15:0] wd;
  logic [1:0]  wl;
  logic        p_ce_n, p_oe_n, p_dq_oe;
  logic [3:0]  p_addr;
  logic [15:0] p_dq;

  assign mem_dq_in = rd_ok ? model_mem[mem_addr] : 16'hDEAD;

  initial begin
    for (int i = 0; i < 16; i++) begin
      model_mem[i] = 16'h0000;
      ref_mem[i]   = 16'h0000;
    end
    wcnt = 0; rcnt = 0; rd_ok = 1'b0; commits = 0; commits_exp = 0;
    p_ce_n = 1'b1; p_oe_n = 1'b1; p_dq_oe = 1'b0; p_addr = '0; p_dq = '0;
    wa = '0; wd = '0; wl = '0;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_we_n && !(mem_ub_n && mem_lb_n)) begin
        wcnt++;
        if (wcnt == 1) begin
          wa = mem_addr; wd = mem_dq_out; wl = {!mem_ub_n, !mem_lb_n};
          if (p_ce_n || !p_dq_oe || p_addr != mem_addr || p_dq != mem_dq_out) begin
            errors++;
            $display("FAIL R2 model: no setup cycle (prev ce_n=%0b dq_oe=%0b addr=%0h, expected ce_n=0 dq_oe=1 addr=%0h)",
                     p_ce_n, p_dq_oe, p_addr, mem_addr);
          end
        end else if (mem_addr != wa || mem_dq_out != wd || !mem_dq_oe) begin
          errors++;
          $display("FAIL R2 model: address/data moved during pulse (addr=%0h data=%h, expected %0h %h)",
                   mem_addr, mem_dq_out, wa, wd);
        end
      end else if (wcnt > 0) begin
        checks++;
        if (wcnt < WP_EXP || mem_ce_n || !mem_dq_oe || mem_addr != wa || mem_dq_out != wd
            || {!mem_ub_n, !mem_lb_n} != wl) begin
          errors++;
          $display("FAIL R3 model: bad write end (pulse=%0d ce_n=%0b dq_oe=%0b lanes=%b, expected pulse>=%0d ce_n=0 dq_oe=1 lanes=%b)",
                   wcnt, mem_ce_n, mem_dq_oe, {!mem_ub_n, !mem_lb_n}, WP_EXP, wl);
        end
        if (wl[1]) model_mem[wa][15:8] = wd[15:8];
        if (wl[0]) model_mem[wa][7:0]  = wd[7:0];
        commits++;
        wcnt = 0;
      end
      if (!mem_ce_n && !mem_oe_n && !mem_ub_n && !mem_lb_n) rcnt++;
      else rcnt = 0;
      rd_ok = (rcnt >= RD_EXP);
      if (mem_dq_oe && (!mem_oe_n || !p_oe_n)) begin
        errors++;
        $display("FAIL R8 model: drivers on with oe_n=%0b prev oe_n=%0b, expected both 1", mem_oe_n, p_oe_n);
      end
      p_ce_n = mem_ce_n; p_oe_n = mem_oe_n; p_dq_oe = mem_dq_oe;
      p_addr = mem_addr; p_dq = mem_dq_out;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [15:0] d, input logic [1:0] m);
    int   n;
    bit   saw_we;
    bit   saw_ce;
    check(req_ready, "R9", "ready before write", int'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 1'b0;
    n = 1; saw_we = !mem_we_n; saw_ce = !mem_ce_n;
    while (!req_ready && n < 60) begin
      @(negedge clk);
      n++;
      saw_we |= !mem_we_n; saw_ce |= !mem_ce_n;
    end
    if (m == 2'b00) begin
      check(n == 2, "R5", "no-op busy length", n, 2);
      check(!saw_we && !saw_ce, "R5", "strobes on no-op", int'({saw_ce, saw_we}), 0);
    end else begin
      check(n == WP_EXP + 3, "R3", "write busy length", n, WP_EXP + 3);
      commits_exp++;
      if (m[1]) ref_mem[a][15:8] = d[15:8];
      if (m[0]) ref_mem[a][7:0]  = d[7:0];
    end
  endtask

  task automatic do_read(input logic [3:0] a, input string req);
    int n;
    check(req_ready, "R9", "ready before read", int'(req_ready), 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    req_mask = 2'b00; // mask ignored on reads
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (n <= RD_EXP) begin
      // R6 strobes during the read window
      check(!mem_ce_n && !mem_oe_n && !mem_ub_n && !mem_lb_n && mem_we_n && mem_addr == a,
            "R6", "read strobes", int'({mem_ce_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_we_n}), 1);
      check(!rd_valid && !req_ready, "R9", "busy during read", int'({rd_valid, req_ready}), 0);
      @(negedge clk);
      n++;
    end
    check(rd_valid, "R7", "rd_valid after window", int'(rd_valid), 1);
    check(rd_data == ref_mem[a], req, "read data", int'(rd_data), int'(ref_mem[a]));
    // R8 turnaround cycle
    check(mem_oe_n && mem_ce_n && !mem_dq_oe && !req_ready, "R8", "turnaround cycle",
          int'({mem_oe_n, mem_ce_n, mem_dq_oe, req_ready}), 4'b1100);
    @(negedge clk);
    check(!rd_valid, "R7", "rd_valid single pulse", int'(rd_valid), 0);
    check(req_ready, "R9", "ready after read", int'(req_ready), 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    int n;
    bit strobe;
    checks = 0; errors = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_mask = '0;
    repeat (4) @(negedge clk);
    check(!req_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !rd_valid,
          "R1", "reset state", int'({req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, rd_valid}), 6'b011100);
    rst_n = 1'b1;
    // R1: request offered during hold-off must be ignored
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd3; req_wdata = 16'hFFFF; req_mask = 2'b11;
    n = 0; strobe = 1'b0;
    while (!req_ready && n < 1000) begin
      if (n == 300) req_valid = 1'b0;
      strobe |= !mem_ce_n;
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    check(n >= PWR_EXP && n <= PWR_EXP + 4, "R1", "power-up hold-off cycles", n, PWR_EXP);
    check(!strobe, "R1", "strobe during hold-off", int'(strobe), 0);
    do_read(4'd3, "R1");

    // full-word writes over every address, then read back
    for (int a = 0; a < 16; a++)
      do_write(4'(a), 16'(a * 16'h1111) ^ 16'hA55A, 2'b11);
    for (int a = 0; a < 16; a++)
      do_read(4'(a), "R2");

    // R4: every mask on two addresses
    for (int a = 5; a < 7; a++) begin
      for (int m = 0; m < 4; m++) begin
        do_write(4'(a), 16'h1234 + 16'(m * 16'h0F0F) + 16'(a), 2'(m));
        do_read(4'(a), "R4");
      end
    end

    // R5: no-op write leaves the word intact, back-to-back with a write
    do_write(4'd9, 16'h0000, 2'b00);
    do_write(4'd9, 16'hBEEF, 2'b10);
    do_write(4'd9, 16'hC0DE, 2'b00);
    do_read(4'd9, "R5");

    // back-to-back read then write (turnaround), R8
    do_read(4'd0, "R8");
    do_write(4'd0, 16'h5AA5, 2'b01);
    do_read(4'd0, "R8");

    check(commits == commits_exp, "R5", "terminating edges seen by memory", commits, commits_exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule